// File: doc/BRIEF.md
# Interrupt Event and Mask Registers

This block gathers interrupt causes for a host controller and drives one interrupt line to the host processor. Hardware sources arrive as single-cycle pulses: one per DMA context, one when a self-ID stream has been received, and one the block raises itself when a register access fails. Each pulse sets a sticky event bit. Software clears event bits by writing ones to a clear address. Software chooses which events may interrupt through a mask register that has separate set and clear addresses. The top mask bit is a master enable over all the others.

The host reaches the block through a plain one-word request port. Reads return their data one cycle later. The block also holds one register that lives in the PHY clock domain. While the PHY clock is reported absent, any access to that register fails without raising an error. A failed write leaves the register untouched, a failed read returns zero, and the failure sets an event bit. A status address reports whether the PHY clock is present.

Top module: `irq_event_regs`

## Requirements
- R1: After reset the event bits, the mask bits and the PHY-domain register are zero, irq is low, and rd_valid is low.
- R2: A one-cycle pulse on ctx_done[i] sets event bit i, and a pulse on selfid_rx sets event bit NUM_CTX. Each event bit stays set until software clears it.
- R3: Writing to address 1 clears every event bit written as one. Bits written as zero keep their value.
- R4: Writing to address 0 sets every event bit written as one. Only bits 0 to NUM_CTX+1 exist.
- R5: Writing to address 2 sets mask bits and writing to address 3 clears mask bits, one bit per one written. Zeros have no effect. Only bits 0 to NUM_CTX+1 and bit 31 exist.
- R6: irq equals mask bit 31 AND the OR over bits 30 to 0 of (event AND mask), taken from the registers after each clock edge.
- R7: If a hardware pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R8: A read request is answered with rd_valid high on the next cycle. rd_data holds the value as it was before any update made in the request cycle. Address 0 returns the events, address 1 returns events AND mask, addresses 2 and 3 return the mask, and addresses 6 and 7 return zero. Bits that do not exist read as zero. Writes to addresses 6 and 7 change nothing.
- R9: Address 4 returns phy_clk_ok in bit 0 and zeros in all other bits.
- R10: Address 5 is a 32-bit PHY-domain register. It can be read and written while phy_clk_ok is high.
- R11: Any access to address 5 while phy_clk_ok is low sets event bit NUM_CTX+1. A failed write leaves the register unchanged, and a failed read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_done | input | NUM_CTX | Per-context DMA completion pulses |
| selfid_rx | input | 1 | Self-ID stream received pulse |
| phy_clk_ok | input | 1 | High while the PHY clock is running |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Interrupt line to the host |

## Verification
The hardest case to reach is a hardware pulse and a software clear that land on the same event bit in the same cycle. The bench gets there by raising ctx_done on the same falling edge on which it drives the clear request, so both are sampled at one rising edge. The bench then reads the bit back. A second hard case is an access to the PHY-domain register while the PHY clock is absent. The bench lowers phy_clk_ok, writes a new value and reads the register, then restores the clock and reads again to show that the stored value did not change. The interrupt output is swept over every event pattern against every mask pattern of the implemented bits, with the master enable both set and cleared.

// File: rtl/irq_event_regs.sv
module irq_event_regs #(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTX-1:0] ctx_done,
  input  logic               selfid_rx,
  input  logic               phy_clk_ok,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               irq
);

  localparam int SID_BIT = NUM_CTX;
  localparam int RAF_BIT = NUM_CTX + 1;
  localparam logic [31:0] EVT_IMPL = (32'd1 << (NUM_CTX + 2)) - 32'd1;
  localparam logic [31:0] MSK_IMPL = EVT_IMPL | 32'h8000_0000;
  localparam logic [ADDR_W-1:0] A_EVT_SET = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EVT_CLR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MSK_SET = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MSK_CLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_LINK    = ADDR_W'(5);

  logic [31:0] evt_q, msk_q, link_q, hw_set, rd_mux;
  logic        wr, rd, link_fail;

  assign wr        = req_valid & req_write;
  assign rd        = req_valid & ~req_write;
  assign link_fail = req_valid & (req_addr == A_LINK) & ~phy_clk_ok;
  assign hw_set    = 32'(ctx_done) | (32'(selfid_rx) << SID_BIT) | (32'(link_fail) << RAF_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      msk_q  <= '0;
      link_q <= '0;
    end else begin
      evt_q <= (((wr && req_addr == A_EVT_CLR) ? evt_q & ~req_wdata : evt_q)
               | ((wr && req_addr == A_EVT_SET) ? req_wdata : 32'd0)
               | hw_set) & EVT_IMPL;
      if (wr && req_addr == A_MSK_SET) msk_q <= (msk_q | req_wdata) & MSK_IMPL;
      else if (wr && req_addr == A_MSK_CLR) msk_q <= msk_q & ~req_wdata;
      if (wr && req_addr == A_LINK && phy_clk_ok) link_q <= req_wdata;
    end
  end

  always_comb begin
    case (req_addr)
      A_EVT_SET:            rd_mux = evt_q;
      A_EVT_CLR:            rd_mux = evt_q & msk_q;
      A_MSK_SET, A_MSK_CLR: rd_mux = msk_q;
      A_STATUS:             rd_mux = {31'd0, phy_clk_ok};
      A_LINK:               rd_mux = phy_clk_ok ? link_q : 32'd0;
      default:              rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
    end
  end

  assign irq = msk_q[31] & |(evt_q & msk_q & 32'h7FFF_FFFF);

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> msk_q[31]); // R6
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctx_done[0])) |-> evt_q[0]); // R7
  AST_SELFID_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(selfid_rx)) |-> evt_q[SID_BIT]); // R2
  AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(link_fail)) |-> evt_q[RAF_BIT]); // R11
  AST_FAIL_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(link_fail && req_write)) |-> $stable(link_q)); // R11
  AST_FAIL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(link_fail && !req_write)) |-> (rd_valid && rd_data == 32'd0)); // R11
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rd_valid) |-> $past(req_valid && !req_write)); // R8

endmodule

// File: tb/test_irq_event_regs.sv
`timescale 1ns/1ps
module test_irq_event_regs;
  localparam int NC = 4;
  logic clk = 0, rst_n = 0;
  logic [NC-1:0] ctx_done = '0;
  logic selfid_rx = 0, phy_clk_ok = 1;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, irq;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_event_regs #(.NUM_CTX(NC), .ADDR_W(3)) i_irq_event_regs (
    .clk(clk), .rst_n(rst_n), .ctx_done(ctx_done), .selfid_rx(selfid_rx),
    .phy_clk_ok(phy_clk_ok), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    chk("R8 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 0);
    rst_n = 1;
    rd(3'd0, v); chk("R1 event", v, 0);
    rd(3'd2, v); chk("R1 mask", v, 0);
    rd(3'd5, v); chk("R1 link", v, 0);

    for (int i = 0; i < NC; i++) begin
      @(negedge clk); ctx_done[i] = 1;
      @(negedge clk); ctx_done[i] = 0;
      repeat (2) @(negedge clk);
      rd(3'd0, v); chk("R2 ctx pulse sticky", v, (32'd1 << (i + 1)) - 1);
    end
    @(negedge clk); selfid_rx = 1;
    @(negedge clk); selfid_rx = 0;
    rd(3'd0, v); chk("R2 selfid", v, 32'h1F);

    wr(3'd1, 32'h0000_0005); rd(3'd0, v); chk("R3 clear ones", v, 32'h1A);
    wr(3'd1, 32'h0); rd(3'd0, v); chk("R3 zeros no effect", v, 32'h1A);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd0, v); chk("R3 clear all", v, 0);

    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R4 sw set impl bits", v, 32'h3F);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R5 mask set", v, 32'h8000_003F);
    wr(3'd3, 32'h0000_0021); rd(3'd3, v); chk("R5 mask clear", v, 32'h8000_001E);
    wr(3'd2, 32'h0); rd(3'd2, v); chk("R5 zero set no effect", v, 32'h8000_001E);
    wr(3'd3, 32'h0); rd(3'd2, v); chk("R5 zero clear no effect", v, 32'h8000_001E);
    rd(3'd1, v); chk("R8 pending", v, 32'h1E);
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'h0);
    rd(3'd6, v); chk("R8 unmapped read", v, 0);
    rd(3'd7, v); chk("R8 unmapped read", v, 0);
    rd(3'd0, v); chk("R8 unmapped write inert", v, 32'h3F);
    rd(3'd2, v); chk("R8 unmapped write inert", v, 32'h8000_001E);

    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 3'd1; req_wdata = 32'h1; ctx_done[0] = 1;
    @(negedge clk); req_valid = 0; req_write = 0; ctx_done[0] = 0;
    rd(3'd0, v); chk("R7 set beats clear", v, 32'h3F);

    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 3'd0; ctx_done = '0;
    @(negedge clk); req_valid = 0;
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 3'd0; ctx_done[2] = 1;
    @(negedge clk); req_valid = 0; ctx_done[2] = 0;
    chk("R8 read sees pre-update value", rd_data, 0);
    wr(3'd1, 32'hFFFF_FFFF);

    for (int m = 0; m < 64; m++) begin
      wr(3'd3, 32'hFFFF_FFFF); wr(3'd2, 32'h8000_0000 | m);
      for (int p = 0; p < 64; p++) begin
        wr(3'd1, 32'hFFFF_FFFF); wr(3'd0, p);
        chk("R6 irq sweep", {31'd0, irq}, {31'd0, (p & m) != 0});
      end
    end
    wr(3'd3, 32'h8000_0000); wr(3'd2, 32'h3F); wr(3'd0, 32'h3F);
    chk("R6 master off", {31'd0, irq}, 0);
    wr(3'd2, 32'h8000_0000);
    chk("R6 master on", {31'd0, irq}, 1);
    wr(3'd1, 32'hFFFF_FFFF);

    rd(3'd4, v); chk("R9 phy present", v, 1);
    wr(3'd5, 32'hA5A5_1234); rd(3'd5, v); chk("R10 link rw", v, 32'hA5A5_1234);
    rd(3'd0, v); chk("R10 no fail event", v, 0);
    phy_clk_ok = 0;
    rd(3'd4, v); chk("R9 phy absent", v, 0);
    wr(3'd5, 32'h1111_1111);
    rd(3'd0, v); chk("R11 fail event", v, 32'h20);
    wr(3'd1, 32'h20);
    rd(3'd5, v); chk("R11 failed read zero", v, 0);
    rd(3'd0, v); chk("R11 read fail event", v, 32'h20);
    phy_clk_ok = 1;
    rd(3'd5, v); chk("R11 failed write inert", v, 32'hA5A5_1234);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule